// File: doc/BRIEF.md
# External memory bus strobe controller

This block turns single access requests from a small processor core into timed cycles on an external memory bus. The core sends a one-clock request pulse with an address, a direction, write data and a flag that says whether the target is external. The controller then runs a cycle in two parts. The first part is the address phase, during which the address strobe pulses low. The second part is the data phase, during which a data strobe pulses low. The read/write line is set at the start of the cycle. A done pulse returns to the core at the end of the cycle, together with any captured read data. Each phase of the cycle lasts two clocks: one clock with the strobe active and one clock with it inactive. The clock that follows the strobe's rising edge gives the outside memory its address-valid and data-valid points.

Two external memories can share the bus with no glue logic. When split mode is selected, a high address bit chooses the strobe: the main data strobe serves the upper block and the second data strobe serves the lower block. Cycles to internal memory still produce the address strobe, but they leave both data strobes and the data bus alone. An active-low wait input stretches the data phase. A bus acknowledge, or a software release bit, takes all bus drivers off the bus. The outputs carry a shared enable for the pads, because the pads themselves are outside this block.

States: `ST_IDLE`, `ST_T1A` (address strobe low), `ST_T1B` (address strobe released, address valid), `ST_T2A` (data strobe low), `ST_TW` (inserted wait, data strobe still low), `ST_T2B` (data strobe released, done). Transitions: IDLE→T1A on a request; T1A→T1B; T1B→T2A; T2A or TW→TW when an external cycle samples wait low; T2A or TW→T2B otherwise; T2B→IDLE.

Top module: `xbus_strobe_ctrl`

## Requirements
- R1: A request accepted in IDLE starts the sequence T1A, T1B, T2A, T2B, one clock each, then returns to IDLE. `as_n` is low only in the clock after the request (T1A), and `addr_out` holds the request address from T1A onward.
- R2: `rw_n` is 1 for a read and 0 for a write. It changes only at the clock edge that accepts a request, and it is held until the next accepted request.
- R3: In an external cycle the selected data strobe is low in T2A and in every wait state. For an external write, `dq_oe` is 1 and `dq_out` equals the request write data from T2A through T2B.
- R4: For an external read, `dq_in` is captured at the edge that ends the last data-strobe-low clock. `rdata` shows this value while `done` is high, and `done` is high for exactly one clock (T2B) per cycle.
- R5: In an internal cycle (`req_ext`=0), `ds_n` and `ds2_n` stay 1, `dq_oe` stays 0, and `wait_n` has no effect on the cycle length.
- R6: When `ds2_en`=1 at request time, an external cycle uses `ds_n` if address bit HI_BIT (default 21) is 1, and uses `ds2_n` if that bit is 0. The two strobes are never low together.
- R7: When `ds2_en`=0 at request time, every external cycle uses `ds_n`, and `ds2_n` stays 1.
- R8: In an external cycle, each rising edge in T2A or TW that samples `wait_n`=0 adds one more data-strobe-low clock.
- R9: While `bus_ack` or `hiz_sw` is 1, `ctl_oe` and `dq_oe` are 0 in that same clock. Sequencing and strobe values continue unchanged.
- R10: During reset, `as_n`, `ds_n`, `ds2_n` and `rw_n` are 1 and `done` is 0.
- R11: A request pulse that arrives while a cycle is in progress is ignored. The running cycle and `addr_out` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | One-clock access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ext | input | 1 | 1 = external target, 0 = internal |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| ds2_en | input | 1 | Split strobe mode select |
| wait_n | input | 1 | Wait request, active low |
| bus_ack | input | 1 | Bus granted to another master |
| hiz_sw | input | 1 | Software bus release |
| dq_in | input | DATA_W | Data from the external bus |
| done | output | 1 | Cycle complete pulse |
| rdata | output | DATA_W | Read data returned to the core |
| addr_out | output | ADDR_W | Latched bus address |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Main/upper data strobe, active low |
| ds2_n | output | 1 | Lower data strobe, active low |
| rw_n | output | 1 | Read (1) / write (0) |
| ctl_oe | output | 1 | Drive enable for the strobes and rw_n |
| dq_out | output | DATA_W | Write data to the bus |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The bench runs external reads and writes to both address halves, with split mode on and off. This separates a wrong choice between the two data strobes from a wrong direction or a wrong data-enable window. Internal cycles are run with wait held low, which shows that they neither pulse a data strobe nor stretch. External cycles with one and with several wait samples show whether the strobe-low window and the read capture point move by one clock per sample. Release inputs raised in the middle of a cycle, and a second request pulsed during a busy cycle, show whether these inputs change only the enables, or wrongly disturb the sequence or the latched address.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1A  = 3'd1,
        ST_T1B  = 3'd2,
        ST_T2A  = 3'd3,
        ST_TW   = 3'd4,
        ST_T2B  = 3'd5
    } xbus_state_e;

    // attributes of the cycle in flight, latched at request time
    typedef struct packed {
        logic write;
        logic ext;
        logic upper;
        logic split;
    } xbus_cyc_t;

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 8,
    parameter int HI_BIT = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic              req_ext,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ds2_en,
    input  logic              wait_n,
    output xbus_state_e       state_o,
    output xbus_cyc_t         cyc_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              rw_n_o,
    output logic              ds_last_o
);

    xbus_state_e state_q, state_d;
    xbus_cyc_t   cyc_q;
    logic        accept;

    assign accept = (state_q == ST_IDLE) && req;

    // last strobe-low clock of the data phase: internal cycles never stretch
    assign ds_last_o = ((state_q == ST_T2A) || (state_q == ST_TW)) &&
                       (!cyc_q.ext || wait_n);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req) state_d = ST_T1A;
            ST_T1A:  state_d = ST_T1B;
            ST_T1B:  state_d = ST_T2A;
            ST_T2A,
            ST_TW:   state_d = ds_last_o ? ST_T2B : ST_TW;
            ST_T2B:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q   <= '0;
            addr_o  <= '0;
            wdata_o <= '0;
            rw_n_o  <= 1'b1;
        end else if (accept) begin
            cyc_q.write <= req_write;
            cyc_q.ext   <= req_ext;
            cyc_q.upper <= req_addr[HI_BIT];
            cyc_q.split <= ds2_en;
            addr_o      <= req_addr;
            wdata_o     <= req_wdata;
            rw_n_o      <= !req_write;
        end
    end

    assign state_o = state_q;
    assign cyc_o   = cyc_q;

    assert_rw_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == ST_IDLE && req) |=> $stable(rw_n_o));

    assert_busy_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && req) |=> $stable(addr_o));

    assert_wait_extends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_T2A || state_q == ST_TW) && cyc_q.ext && !wait_n)
        |=> (state_q == ST_TW));

    assert_t1_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T1A) |=> (state_q == ST_T1B));

endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  xbus_state_e state,
    input  xbus_cyc_t   cyc,
    input  logic        bus_ack,
    input  logic        hiz_sw,
    output logic        as_n,
    output logic        ds_n,
    output logic        ds2_n,
    output logic        dq_oe,
    output logic        ctl_oe
);

    logic ds_phase;
    logic drive_phase;
    logic use_lower;

    always_comb begin
        as_n        = 1'b1;
        ds_phase    = 1'b0;
        drive_phase = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_T1A:  as_n = 1'b0;
            ST_T1B:  ;
            ST_T2A,
            ST_TW: begin
                ds_phase    = 1'b1;
                drive_phase = 1'b1;
            end
            ST_T2B:  drive_phase = 1'b1;
            default: ;
        endcase
    end

    assign use_lower = cyc.split && !cyc.upper;
    assign ds_n      = !(ds_phase && cyc.ext && !use_lower);
    assign ds2_n     = !(ds_phase && cyc.ext && use_lower);
    assign ctl_oe    = !(bus_ack || hiz_sw);
    assign dq_oe     = ctl_oe && drive_phase && cyc.ext && cyc.write;

    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ds_n && !ds2_n));

    assert_internal_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !cyc.ext) |-> (ds_n && ds2_n && !dq_oe));

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack || hiz_sw) |-> (!ctl_oe && !dq_oe));

    assert_lower_unused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc.split |-> ds2_n);

endmodule

// File: rtl/xbus_rdata.sv
module xbus_rdata
    import xbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xbus_state_e       state,
    input  logic              ds_last,
    input  logic              rd_cycle,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            done <= ds_last;
            if (ds_last && rd_cycle) begin
                rdata <= dq_in;
            end
        end
    end

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_in_t2b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state == ST_T2B));

endmodule

// File: rtl/xbus_strobe_ctrl.sv
module xbus_strobe_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 8,
    parameter int HI_BIT = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic              req_ext,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ds2_en,
    input  logic              wait_n,
    input  logic              bus_ack,
    input  logic              hiz_sw,
    input  logic [DATA_W-1:0] dq_in,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr_out,
    output logic              as_n,
    output logic              ds_n,
    output logic              ds2_n,
    output logic              rw_n,
    output logic              ctl_oe,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    xbus_state_e state;
    xbus_cyc_t   cyc;
    logic        ds_last;

    xbus_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .HI_BIT (HI_BIT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_write (req_write),
        .req_ext   (req_ext),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ds2_en    (ds2_en),
        .wait_n    (wait_n),
        .state_o   (state),
        .cyc_o     (cyc),
        .addr_o    (addr_out),
        .wdata_o   (dq_out),
        .rw_n_o    (rw_n),
        .ds_last_o (ds_last)
    );

    xbus_strobe_gen u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .cyc     (cyc),
        .bus_ack (bus_ack),
        .hiz_sw  (hiz_sw),
        .as_n    (as_n),
        .ds_n    (ds_n),
        .ds2_n   (ds2_n),
        .dq_oe   (dq_oe),
        .ctl_oe  (ctl_oe)
    );

    xbus_rdata #(
        .DATA_W (DATA_W)
    ) u_rdata (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .ds_last  (ds_last),
        .rd_cycle (!cyc.write),
        .dq_in    (dq_in),
        .rdata    (rdata),
        .done     (done)
    );

    // address strobe pulse precedes every data strobe by two clocks
    assert_as_leads_ds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ds_n) || $fell(ds2_n)) |-> ($past(as_n, 2) == 1'b0));

    assert_as_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |=> as_n);

endmodule

// File: tb/xbus_strobe_ctrl_tb.sv
module xbus_strobe_ctrl_tb;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 22;
    localparam int DATA_W = 8;
    localparam int HI_BIT = 21;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0, req_write = 1'b0, req_ext = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              ds2_en = 1'b0, wait_n = 1'b1, bus_ack = 1'b0, hiz_sw = 1'b0;
    logic [DATA_W-1:0] dq_in = 8'h11;
    logic              done, as_n, ds_n, ds2_n, rw_n, ctl_oe, dq_oe;
    logic [DATA_W-1:0] rdata, dq_out;
    logic [ADDR_W-1:0] addr_out;

    int checks = 0;
    int errors = 0;

    xbus_strobe_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_BIT(HI_BIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write), .req_ext(req_ext),
        .req_addr(req_addr), .req_wdata(req_wdata), .ds2_en(ds2_en), .wait_n(wait_n),
        .bus_ack(bus_ack), .hiz_sw(hiz_sw), .dq_in(dq_in), .done(done), .rdata(rdata),
        .addr_out(addr_out), .as_n(as_n), .ds_n(ds_n), .ds2_n(ds2_n), .rw_n(rw_n),
        .ctl_oe(ctl_oe), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #(CLK_P/2) clk = ~clk;

    // changing read data pattern on the bus
    always @(negedge clk) dq_in <= dq_in * 8'd5 + 8'd3;

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int                m_ph = 0;   // 0 idle, 1 addr strobe, 2 addr valid, 3 data strobe low, 4 finish
    int                m_waits = 0;
    bit                m_wr = 0, m_ext = 0, m_up = 0, m_split = 0, m_rwn = 1;
    logic [ADDR_W-1:0] m_addr = '0;
    logic [DATA_W-1:0] m_wdata = '0, m_rdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph <= 0; m_rwn <= 1; m_addr <= '0; m_wdata <= '0; m_rdata <= '0;
            m_wr <= 0; m_ext <= 0; m_up <= 0; m_split <= 0; m_waits <= 0;
        end else begin
            if (m_ph == 0) begin
                if (req) begin
                    m_ph <= 1; m_wr <= req_write; m_ext <= req_ext;
                    m_up <= req_addr[HI_BIT]; m_split <= ds2_en; m_rwn <= !req_write;
                    m_addr <= req_addr; m_wdata <= req_wdata; m_waits <= 0;
                end
            end else if (m_ph == 3) begin
                if (m_ext && !wait_n) m_waits <= m_waits + 1;
                else begin
                    m_ph <= 4;
                    if (!m_wr) m_rdata <= dq_in;
                end
            end else if (m_ph == 4) m_ph <= 0;
            else m_ph <= m_ph + 1;
        end
    end

    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst_n) begin
            bit low_ds, oe;
            string dtag;
            low_ds = (m_ph == 3) && m_ext;
            oe = !(bus_ack || hiz_sw);
            dtag = !m_ext ? "R5" : (m_waits > 0 && m_ph == 3) ? "R8" : m_split ? "R6" : "R7";
            check("R1", "as_n", as_n, !(m_ph == 1));
            check("R1", "addr_out", addr_out, m_addr);
            check("R2", "rw_n", rw_n, m_rwn);
            check(dtag, "ds_n", ds_n, !(low_ds && !(m_split && !m_up)));
            check(dtag, "ds2_n", ds2_n, !(low_ds && m_split && !m_up));
            check("R9", "ctl_oe", ctl_oe, oe);
            check(m_ext ? "R3" : "R5", "dq_oe", dq_oe,
                  oe && m_wr && m_ext && (m_ph == 3 || m_ph == 4));
            if (dq_oe) check("R3", "dq_out", dq_out, m_wdata);
            check("R4", "done", done, m_ph == 4);
            if (m_ph == 4 && !m_wr && m_ext) check("R4", "rdata", rdata, m_rdata);
        end
    end

    // ---------------- stimulus ----------------
    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic access(input bit wr, input bit ext, input bit split,
                          input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] wd,
                          input int nwait, input bit poke);
        @(negedge clk);
        req = 1; req_write = wr; req_ext = ext; ds2_en = split; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req = 0; req_write = !wr; ds2_en = !split; req_addr = ~addr;
        @(negedge clk);
        if (poke) req = 1;               // R11: request while busy
        @(negedge clk);
        req = 0;
        for (int i = 0; i < nwait; i++) begin
            wait_n = 0;
            @(negedge clk);
        end
        wait_n = 1;
        for (int i = 0; i < 12 && !done; i++) @(negedge clk);
        @(negedge clk);
    endtask

    int wd_cnt = 0;
    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values
        check("R10", "as_n", as_n, 1); check("R10", "ds_n", ds_n, 1);
        check("R10", "ds2_n", ds2_n, 1); check("R10", "rw_n", rw_n, 1);
        check("R10", "done", done, 0);
        rst_n = 1;
        // R6/R4: split mode reads, upper then lower block
        access(0, 1, 1, 22'h20_0010, 8'h00, 0, 0);
        access(0, 1, 1, 22'h00_0123, 8'h00, 0, 0);
        // R3/R6: split mode writes
        access(1, 1, 1, 22'h3F_0001, 8'hA5, 0, 0);
        access(1, 1, 1, 22'h01_0002, 8'h5A, 0, 0);
        // R7: no split, both halves on the main strobe
        access(0, 1, 0, 22'h00_0044, 8'h00, 0, 0);
        access(1, 1, 0, 22'h00_0055, 8'h3C, 0, 0);
        access(1, 1, 0, 22'h20_0066, 8'hC3, 0, 0);
        // R5: internal cycles, wait held low must be ignored
        access(0, 0, 1, 22'h00_0077, 8'h00, 3, 0);
        access(1, 0, 0, 22'h20_0088, 8'h99, 3, 0);
        // R8: wait states, one and several
        access(0, 1, 1, 22'h00_0100, 8'h00, 1, 0);
        access(1, 1, 1, 22'h20_0200, 8'h77, 4, 0);
        access(0, 1, 0, 22'h20_0300, 8'h00, 2, 0);
        // R11: second request during a busy cycle
        access(0, 1, 1, 22'h00_0400, 8'h00, 0, 1);
        access(1, 1, 0, 22'h00_0500, 8'h12, 1, 1);
        // R9: release inputs during cycles
        fork
            access(1, 1, 1, 22'h20_0600, 8'hEE, 1, 0);
            begin repeat (3) @(negedge clk); hiz_sw = 1; repeat (2) @(negedge clk); hiz_sw = 0; end
        join
        fork
            access(1, 1, 0, 22'h00_0700, 8'hDD, 0, 0);
            begin repeat (4) @(negedge clk); bus_ack = 1; @(negedge clk); bus_ack = 0; end
        join
        access(0, 1, 1, 22'h00_0800, 8'h00, 0, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule